// File: doc/BRIEF.md
# Transmit Descriptor Write-Back Coalescer

This block decides when completed transmit descriptors are handed back to host memory. The descriptor engine reports completed descriptors one per cycle at most, each with a report-status flag. The coalescer keeps a count of descriptors waiting for write-back. At the right moment it raises a write-back request that carries the number of descriptors to flush. The host-bus side accepts the request with an acknowledge. One cycle after that handshake the block pulses a done event, which the interrupt logic can use.

Two static configuration inputs select the policy. A threshold of zero selects immediate mode: each completed descriptor that carries the report-status flag is flushed as soon as possible. A nonzero threshold selects batching mode, which has two triggers. Descriptors are flushed once their count reaches the threshold. A delay timer, clocked by ticks from a built-in free-running prescaler, flushes a partial batch once it runs out.

Top module: `wb_coalesce_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `wb_req` and `wb_done` are 0 and `wb_count` is 0.
- R2: With `cfg_thresh` = 0, a completed descriptor (`desc_valid`) counts as pending only when `desc_rs` is 1; one with `desc_rs` = 0 never leads to a request. In any cycle with `wb_req` low and a nonzero pending count, `wb_req` rises at the next edge.
- R3: With `cfg_thresh` nonzero, every completed descriptor counts as pending whatever `desc_rs` is. A request is raised at the edge after a cycle in which no request is held and the pending count is at least `cfg_thresh`.
- R4: In batching mode, a pending descriptor that arrives while the timer is idle loads `cfg_delay` into the timer. The timer decrements on each prescaler tick, which comes once every PRESCALE cycles counted from reset. It expires on a tick at which its value is 0, so a loaded 0 expires on the next tick.
- R5: After the timer expires, every pending descriptor is flushed at the next opportunity, even when there are fewer than `cfg_thresh`.
- R6: Raising a request stops the timer and clears expiry. A descriptor that arrives in the same cycle is counted for the next batch and restarts the timer.
- R7: When the threshold is met and the timer has expired in the same cycle, exactly one request is raised, and it covers all pending descriptors.
- R8: `wb_req` stays high and `wb_count` stays unchanged until `wb_ack`; `wb_count` is nonzero while `wb_req` is high. Descriptors that arrive meanwhile stay pending for a later request. A new request can rise no earlier than two edges after the acknowledged cycle.
- R9: `wb_done` is high for exactly the one cycle after each cycle with `wb_req` and `wb_ack` both high.
- R10: In immediate mode the timer is idle and holds no expiry, so flushes depend only on the pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_thresh | input | THR_W | Batch threshold; 0 selects immediate mode |
| cfg_delay | input | DLY_W | Delay timer load value, in prescaler ticks |
| desc_valid | input | 1 | A descriptor completed this cycle |
| desc_rs | input | 1 | Report-status flag of that descriptor |
| wb_req | output | 1 | Write-back request |
| wb_count | output | CNT_W | Number of descriptors to flush with this request |
| wb_ack | input | 1 | Write-back accepted |
| wb_done | output | 1 | One-cycle write-back completion event |

## Verification
A behavioural model predicts the block's outputs for every cycle. Immediate mode is driven with a random mix of flagged and unflagged descriptors; this separates counting only flagged descriptors from counting all of them. A moderate threshold with a very long delay exercises the count path alone. A high threshold with a short delay and sparse arrivals makes the timer the only trigger. A small threshold with a zero delay and slow acknowledges makes the threshold and the timer fire together and makes descriptors pile up behind a held request. A final return to immediate mode checks that leftover batching state does not cause flushes.

// File: rtl/wb_coalesce_pkg.sv
package wb_coalesce_pkg;
  typedef enum logic {MODE_IMMED = 1'b0, MODE_BATCH = 1'b1} wb_mode_e;

  function automatic wb_mode_e mode_of(input logic thr_nonzero);
    return thr_nonzero ? MODE_BATCH : MODE_IMMED;
  endfunction
endpackage

// File: rtl/coal_prescaler.sv
module coal_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);

      // R4: ticks are spaced, never on back-to-back cycles
      assert_tick_spaced_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end else begin : g_every
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             batch,
  input  logic             tick,
  input  logic             start_evt,
  input  logic             flush,
  input  logic [DLY_W-1:0] load_val,
  output logic             expired
);
  logic             run_q;
  logic [DLY_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst || !batch) begin
      run_q   <= 1'b0;
      val_q   <= '0;
      expired <= 1'b0;
    end else if (flush) begin
      // R6: a flush re-initialises; an arrival in the same cycle restarts
      expired <= 1'b0;
      run_q   <= start_evt;
      val_q   <= load_val;
    end else if (!run_q && !expired && start_evt) begin
      run_q <= 1'b1;
      val_q <= load_val;
    end else if (run_q && tick) begin
      if (val_q == '0) begin
        run_q   <= 1'b0;
        expired <= 1'b1;
      end else begin
        val_q <= val_q - 1'b1;
      end
    end
  end

  // R10: timer holds no state in immediate mode
  assert_idle_immed_R10: assert property (@(posedge clk) disable iff (rst)
    !batch |=> (!run_q && !expired));
  // R4: expiry only follows a tick of a running timer
  assert_expire_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(expired) |-> $past(tick && run_q));
endmodule

// File: rtl/coal_accum.sv
module coal_accum #(
  parameter int THR_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [THR_W-1:0] thresh,
  input  logic             batch,
  input  logic             desc_valid,
  input  logic             desc_rs,
  input  logic             expired,
  input  logic             wb_ack,
  output logic             inc,
  output logic             issue,
  output logic             wb_req,
  output logic [CNT_W-1:0] wb_count,
  output logic             wb_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] pend_q;
  logic [CNT_W-1:0] base;
  logic             thr_hit;

  assign inc     = desc_valid && (batch || desc_rs);
  assign thr_hit = pend_q >= CNT_W'(thresh);
  assign issue   = !wb_req && (pend_q != '0) && (!batch || thr_hit || expired);
  assign base    = issue ? '0 : pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      wb_req   <= 1'b0;
      wb_count <= '0;
      wb_done  <= 1'b0;
    end else begin
      if (inc && base != CNT_MAX) pend_q <= base + 1'b1;
      else                        pend_q <= base;
      wb_done <= wb_req && wb_ack;
      if (issue) begin
        wb_req   <= 1'b1;
        wb_count <= pend_q;
      end else if (wb_req && wb_ack) begin
        wb_req <= 1'b0;
      end
    end
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_count)));
  assert_req_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> (wb_count != '0));
  assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (wb_req && wb_ack) |=> wb_done);
  assert_done_only_R9: assert property (@(posedge clk) disable iff (rst)
    !(wb_req && wb_ack) |=> !wb_done);
endmodule

// File: rtl/wb_coalesce_ctrl.sv
module wb_coalesce_ctrl #(
  parameter int THR_W    = 8,
  parameter int CNT_W    = 8,
  parameter int DLY_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [THR_W-1:0] cfg_thresh,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             desc_valid,
  input  logic             desc_rs,
  output logic             wb_req,
  output logic [CNT_W-1:0] wb_count,
  input  logic             wb_ack,
  output logic             wb_done
);
  import wb_coalesce_pkg::*;

  wb_mode_e mode;
  logic     batch, tick, inc, issue, expired;

  assign mode  = mode_of(cfg_thresh != '0);
  assign batch = (mode == MODE_BATCH);

  coal_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  coal_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk(clk), .rst(rst), .batch(batch), .tick(tick),
    .start_evt(inc), .flush(issue), .load_val(cfg_delay), .expired(expired)
  );

  coal_accum #(.THR_W(THR_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .thresh(cfg_thresh), .batch(batch),
    .desc_valid(desc_valid), .desc_rs(desc_rs), .expired(expired),
    .wb_ack(wb_ack), .inc(inc), .issue(issue),
    .wb_req(wb_req), .wb_count(wb_count), .wb_done(wb_done)
  );
endmodule

// File: tb/test_wb_coalesce_ctrl.sv
module test_wb_coalesce_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PRESCALE   = 4;
  localparam int CNT_MAX    = 255;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_thresh = '0;
  logic [15:0] cfg_delay = '0;
  logic        desc_valid = 1'b0, desc_rs = 1'b0, wb_ack = 1'b0;
  logic        wb_req, wb_done;
  logic [7:0]  wb_count;

  int checks = 0, errors = 0;
  string tag = "R1";

  // reference model state (value after the most recent edge)
  int m_pend = 0, m_req = 0, m_cnt = 0, m_done = 0;
  int m_run = 0, m_val = 0, m_exp = 0, m_cyc = 0;

  wb_coalesce_ctrl #(.PRESCALE(PRESCALE)) i_wb_coalesce_ctrl (
    .clk(clk), .rst(rst), .cfg_thresh(cfg_thresh), .cfg_delay(cfg_delay),
    .desc_valid(desc_valid), .desc_rs(desc_rs), .wb_req(wb_req),
    .wb_count(wb_count), .wb_ack(wb_ack), .wb_done(wb_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    check("wb_req", int'(wb_req), m_req);
    check("wb_done", int'(wb_done), m_done);
    if (m_req != 0 || rst) check("wb_count", int'(wb_count), m_cnt);
  endtask

  // Behavioural prediction of the next edge from requirements R1..R10
  task automatic model_step();
    bit batch, inc, tick, iss;
    int base;
    if (rst) begin
      m_pend = 0; m_req = 0; m_cnt = 0; m_done = 0;
      m_run = 0; m_val = 0; m_exp = 0; m_cyc = 0;
      return;
    end
    batch = (cfg_thresh != 0);
    inc   = desc_valid && (batch || desc_rs);           // R2, R3
    tick  = (m_cyc % PRESCALE) == PRESCALE - 1;         // R4
    iss   = (m_req == 0) && (m_pend > 0) &&
            (!batch || m_pend >= cfg_thresh || m_exp != 0); // R3, R5, R7
    base  = iss ? 0 : m_pend;
    m_done = (m_req != 0 && wb_ack) ? 1 : 0;            // R9
    if (iss) begin m_req = 1; m_cnt = m_pend; end
    else if (m_req != 0 && wb_ack) m_req = 0;           // R8
    m_pend = (inc && base < CNT_MAX) ? base + 1 : base;
    if (!batch) begin m_run = 0; m_val = 0; m_exp = 0; end // R10
    else if (iss) begin m_exp = 0; m_run = inc; m_val = cfg_delay; end // R6
    else if (m_run == 0 && m_exp == 0 && inc) begin m_run = 1; m_val = cfg_delay; end
    else if (m_run != 0 && tick) begin
      if (m_val == 0) begin m_run = 0; m_exp = 1; end
      else m_val--;
    end
    m_cyc++;
  endtask

  function automatic bit pct(input int p);
    return ($urandom % 100) < p;
  endfunction

  initial begin
    void'($urandom(7));
    for (int cyc = 0; cyc < 3600; cyc++) begin
      @(negedge clk);
      compare();
      if (cyc < 3) begin
        rst = 1'b1; tag = "R1";
      end else if (cyc < 800) begin
        // immediate mode, mixed flags: R2, R8, R9
        rst = 1'b0; tag = "R2/R8/R9"; cfg_thresh = 0; cfg_delay = 5;
        desc_valid = pct(50); desc_rs = pct(50); wb_ack = pct(60);
      end else if (cyc < 1600) begin
        // threshold path only, timer never runs out: R3, R6
        tag = "R3/R6"; cfg_thresh = 4; cfg_delay = 1000;
        desc_valid = pct(50); desc_rs = pct(20); wb_ack = pct(60);
      end else if (cyc < 2400) begin
        // timer path, sparse arrivals under a high threshold: R4, R5
        tag = "R4/R5"; cfg_thresh = 30; cfg_delay = 3;
        desc_valid = pct(10); desc_rs = pct(50); wb_ack = pct(70);
      end else if (cyc < 3200) begin
        // zero delay, small threshold, slow ack: R7, R6, R8
        tag = "R7/R6/R8"; cfg_thresh = 2; cfg_delay = 0;
        desc_valid = pct(30); desc_rs = pct(50); wb_ack = pct(30);
      end else begin
        // back to immediate mode: R10, R2
        tag = "R10/R2"; cfg_thresh = 0; cfg_delay = 0;
        desc_valid = pct(40); desc_rs = pct(30); wb_ack = pct(50);
      end
      model_step();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule